// File: doc/BRIEF.md
# Layer Priority Pixel Mixer

This block merges, one pixel at a time, the outputs of a sprite layer, two scrolling background planes (A and B) and a fixed background colour into a single displayed colour. Every layer pixel is a 7-bit code. Bit 6 is a priority bit. Bits 5:4 select a palette. Bits 3:0 select a colour within that palette. Bits 5:0 together address a 64-entry, 12-bit colour table held inside the block. A window input can take the place of plane A. When it does, the result is tagged as coming from the window.

An optional shadow/highlight mode turns two sprite codes into operators. These sprites are not drawn. Instead they darken or brighten whatever the planes show underneath. In this mode the block also flags pixels that no high-priority layer covers as shadowed, and it clears the lowest bit of each 4-bit colour component.

The colour table is loaded through a simple write port. Each pixel travels through one register stage, marked by a valid flag.

Top module: `pixel_mixer`

## Requirements
- R1: While rst_ni is low, and until the first valid pixel arrives, valid_o, color_o, prio_o, src_o, shadow_o and hilite_o are all 0.
- R2: valid_o equals valid_i from one clock earlier. All other outputs are updated only on cycles where valid_i was high, and otherwise keep their values.
- R3: A layer pixel is transparent when bits 3:0 are zero, whatever its other bits hold. If every layer is transparent, the colour index is bg_idx_i, src_o is 0 (background) and prio_o is 0.
- R4: With shadow/highlight mode off, the first opaque pixel wins in this order: sprite with bit 6 set, A with bit 6 set, B with bit 6 set, sprite, A, B. src_o reports 1 for sprite, 2 for plane A and 3 for plane B.
- R5: When win_act_i is 1, win_px_i is used in plane A's place, and a win by that pixel reports src_o = 4. When win_act_i is 0, src_o is never 4.
- R6: color_o is the colour-table entry addressed by bits 5:0 of the winning pixel (or by bg_idx_i), and prio_o is bit 6 of the winner.
- R7: A colour-table write (cram_we_i, cram_addr_i, cram_data_i) takes effect for pixels presented on later cycles. A pixel presented in the same cycle as the write reads the old entry.
- R8: In shadow/highlight mode, a sprite whose bits 5:0 equal 0x3F is an operator. The winner is picked from the planes only, in this order: A with bit 6, B with bit 6, A, B, background. shadow_o is 1, hilite_o is 0, and src_o is never 1.
- R9: In shadow/highlight mode, a sprite whose bits 5:0 equal 0x3E acts like the 0x3F case, except that hilite_o is 1 and shadow_o is 0.
- R10: In shadow/highlight mode with a non-operator sprite, when no opaque high-priority pixel wins, shadow_o is 1 exactly when neither plane pixel (A or its window replacement, and B) has bit 6 set. Opacity does not matter for this test. A high-priority win gives shadow_o = 0.
- R11: In shadow/highlight mode, color_o is the table entry ANDed with 0xEEE.
- R12: With shadow/highlight mode off, shadow_o and hilite_o are 0, color_o is not masked, and sprite codes 0x3E/0x3F are ordinary opaque pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Pixel inputs are valid this cycle |
| spr_px_i | input | 7 | Sprite layer pixel |
| pla_px_i | input | 7 | Plane A pixel |
| plb_px_i | input | 7 | Plane B pixel |
| win_px_i | input | 7 | Window pixel |
| win_act_i | input | 1 | Window replaces plane A |
| sh_mode_i | input | 1 | Shadow/highlight mode enable |
| bg_idx_i | input | 6 | Background colour-table index |
| cram_we_i | input | 1 | Colour-table write enable |
| cram_addr_i | input | 6 | Colour-table write address |
| cram_data_i | input | 12 | Colour-table write data |
| valid_o | output | 1 | Output pixel valid |
| color_o | output | 12 | Resolved colour value |
| prio_o | output | 1 | Priority bit of the winning pixel |
| src_o | output | 3 | Source: 0 bg, 1 sprite, 2 A, 3 B, 4 window |
| shadow_o | output | 1 | Pixel is shadowed |
| hilite_o | output | 1 | Pixel is highlighted |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle valid latency and that outputs hold when no pixel is valid;
- that shadow and highlight never appear together;
- that no flag appears when the mode is off;
- the 0xEEE mask;
- that operator sprites never become the source;
- that no window tag appears without an active window.

The bench scenarios cover what needs known inputs and table contents:
- the exact six-level winner, including transparent pixels that carry priority or palette bits;
- the window override;
- the rule that a same-cycle write reads the old entry;
- the shadow decision, which depends on plane priority bits and not on opacity.

// File: rtl/pixmix_pkg.sv
package pixmix_pkg;
  localparam int PX_W   = 7;
  localparam int CIDX_W = 6;

  typedef enum logic [2:0] {
    SRC_BG  = 3'd0,
    SRC_SPR = 3'd1,
    SRC_A   = 3'd2,
    SRC_B   = 3'd3,
    SRC_WIN = 3'd4
  } src_e;

  typedef struct packed {
    logic       prio;
    logic [1:0] pal;
    logic [3:0] col;
  } px_t;
endpackage

// File: rtl/pixmix_resolve.sv
module pixmix_resolve
  import pixmix_pkg::*;
(
  input  px_t                spr_i,
  input  px_t                pla_i,
  input  px_t                plb_i,
  input  logic               a_is_win_i,
  input  logic               sh_mode_i,
  input  logic [CIDX_W-1:0]  bg_idx_i,
  output logic [CIDX_W-1:0]  idx_o,
  output logic               prio_o,
  output src_e               src_o,
  output logic               shadow_o,
  output logic               hilite_o
);
  logic spr_op, a_op, b_op, s_hi, a_hi, b_hi, sh_op;
  src_e a_src;

  assign spr_op = |spr_i.col;
  assign a_op   = |pla_i.col;
  assign b_op   = |plb_i.col;
  assign s_hi   = spr_op & spr_i.prio;
  assign a_hi   = a_op & pla_i.prio;
  assign b_hi   = b_op & plb_i.prio;
  assign a_src  = a_is_win_i ? SRC_WIN : SRC_A;
  // sprite codes 0x3E/0x3F act as operators in shadow/highlight mode
  assign sh_op  = sh_mode_i & ({spr_i.pal, spr_i.col[3:1]} == 5'b11111);

  always_comb begin
    idx_o    = bg_idx_i;
    prio_o   = 1'b0;
    src_o    = SRC_BG;
    shadow_o = 1'b0;
    hilite_o = 1'b0;
    if (sh_op) begin
      shadow_o = spr_i.col[0];
      hilite_o = ~spr_i.col[0];
      if (a_hi || (!b_hi && a_op)) begin
        idx_o = {pla_i.pal, pla_i.col}; prio_o = pla_i.prio; src_o = a_src;
      end else if (b_op) begin
        idx_o = {plb_i.pal, plb_i.col}; prio_o = plb_i.prio; src_o = SRC_B;
      end
    end else if (s_hi) begin
      idx_o = {spr_i.pal, spr_i.col}; prio_o = 1'b1; src_o = SRC_SPR;
    end else if (a_hi) begin
      idx_o = {pla_i.pal, pla_i.col}; prio_o = 1'b1; src_o = a_src;
    end else if (b_hi) begin
      idx_o = {plb_i.pal, plb_i.col}; prio_o = 1'b1; src_o = SRC_B;
    end else begin
      shadow_o = sh_mode_i & ~(pla_i.prio | plb_i.prio);
      if (spr_op) begin
        idx_o = {spr_i.pal, spr_i.col}; prio_o = spr_i.prio; src_o = SRC_SPR;
      end else if (a_op) begin
        idx_o = {pla_i.pal, pla_i.col}; prio_o = pla_i.prio; src_o = a_src;
      end else if (b_op) begin
        idx_o = {plb_i.pal, plb_i.col}; prio_o = plb_i.prio; src_o = SRC_B;
      end
    end
  end
endmodule

// File: rtl/pixmix_cram.sv
module pixmix_cram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pixel_mixer.sv
module pixel_mixer
  import pixmix_pkg::*;
#(
  parameter int COLOR_W = 12,
  parameter int COMP_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [PX_W-1:0]    spr_px_i,
  input  logic [PX_W-1:0]    pla_px_i,
  input  logic [PX_W-1:0]    plb_px_i,
  input  logic [PX_W-1:0]    win_px_i,
  input  logic               win_act_i,
  input  logic               sh_mode_i,
  input  logic [CIDX_W-1:0]  bg_idx_i,
  input  logic               cram_we_i,
  input  logic [CIDX_W-1:0]  cram_addr_i,
  input  logic [COLOR_W-1:0] cram_data_i,
  output logic               valid_o,
  output logic [COLOR_W-1:0] color_o,
  output logic               prio_o,
  output logic [2:0]         src_o,
  output logic               shadow_o,
  output logic               hilite_o
);
  px_t               a_px;
  logic [CIDX_W-1:0] sel_idx;
  logic              sel_prio, sel_shadow, sel_hilite;
  src_e              sel_src;
  logic [COLOR_W-1:0] raw_col, sh_mask, mix_col;

  assign a_px = win_act_i ? px_t'(win_px_i) : px_t'(pla_px_i);

  pixmix_resolve u_resolve (
    .spr_i      (px_t'(spr_px_i)),
    .pla_i      (a_px),
    .plb_i      (px_t'(plb_px_i)),
    .a_is_win_i (win_act_i),
    .sh_mode_i  (sh_mode_i),
    .bg_idx_i   (bg_idx_i),
    .idx_o      (sel_idx),
    .prio_o     (sel_prio),
    .src_o      (sel_src),
    .shadow_o   (sel_shadow),
    .hilite_o   (sel_hilite)
  );

  pixmix_cram #(.ADDR_W(CIDX_W), .DATA_W(COLOR_W)) u_cram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cram_we_i),
    .waddr_i (cram_addr_i),
    .wdata_i (cram_data_i),
    .raddr_i (sel_idx),
    .rdata_o (raw_col)
  );

  // clear the lowest bit of every colour component
  for (genvar g = 0; g < COLOR_W; g++) begin : g_mask
    assign sh_mask[g] = (g % COMP_W) != 0;
  end

  assign mix_col = sh_mode_i ? (raw_col & sh_mask) : raw_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      color_o  <= '0;
      prio_o   <= 1'b0;
      src_o    <= SRC_BG;
      shadow_o <= 1'b0;
      hilite_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        color_o  <= mix_col;
        prio_o   <= sel_prio;
        src_o    <= sel_src;
        shadow_o <= sel_shadow;
        hilite_o <= sel_hilite;
      end
    end
  end
endmodule

// File: rtl/pixel_mixer_chk.sv
module pixel_mixer_chk #(
  parameter int COLOR_W = 12,
  parameter int COMP_W  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [6:0]         spr_px_i,
  input logic               win_act_i,
  input logic               sh_mode_i,
  input logic               valid_o,
  input logic [COLOR_W-1:0] color_o,
  input logic               prio_o,
  input logic [2:0]         src_o,
  input logic               shadow_o,
  input logic               hilite_o
);
  logic [COLOR_W-1:0] low_bits;
  for (genvar g = 0; g < COLOR_W; g++) begin : g_lb
    assign low_bits[g] = (g % COMP_W) == 0;
  end

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(color_o) && $stable(src_o) && $stable(prio_o));
  a_r5_no_win_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !win_act_i |=> src_o != 3'd4);
  a_r8_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shadow_o && hilite_o));
  a_r8_op_not_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sh_mode_i && (spr_px_i[5:1] == 5'b11111) |=> src_o != 3'd1);
  a_r11_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sh_mode_i |=> (color_o & low_bits) == '0);
  a_r12_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !sh_mode_i |=> !shadow_o && !hilite_o);
  a_r4_src_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_o <= 3'd4);
endmodule

bind pixel_mixer pixel_mixer_chk #(.COLOR_W(COLOR_W), .COMP_W(COMP_W)) u_chk (.*);

// File: tb/tb_pixel_mixer.sv
module tb_pixel_mixer;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [6:0] spr_px_i = '0, pla_px_i = '0, plb_px_i = '0, win_px_i = '0;
  logic win_act_i = 1'b0, sh_mode_i = 1'b0;
  logic [5:0] bg_idx_i = '0;
  logic cram_we_i = 1'b0;
  logic [5:0] cram_addr_i = '0;
  logic [11:0] cram_data_i = '0;
  logic valid_o, prio_o, shadow_o, hilite_o;
  logic [11:0] color_o;
  logic [2:0] src_o;

  int n_chk = 0, n_fail = 0;
  logic [11:0] tbl [64];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pixel_mixer dut (.*);

  function automatic logic [11:0] pat(int i);
    return 12'((i * 12'h111) ^ 12'h5A5);
  endfunction

  task automatic chk(string req, logic [5:0] idx, logic [2:0] src, logic pr,
                     logic sh, logic hl, logic msk);
    logic [11:0] ec;
    ec = msk ? (tbl[idx] & 12'hEEE) : tbl[idx];
    n_chk++;
    if (valid_o !== 1'b1 || color_o !== ec || src_o !== src || prio_o !== pr ||
        shadow_o !== sh || hilite_o !== hl) begin
      n_fail++;
      $display("FAIL %s: got v=%b col=%h src=%0d pr=%b sh=%b hl=%b exp v=1 col=%h src=%0d pr=%b sh=%b hl=%b",
               req, valid_o, color_o, src_o, prio_o, shadow_o, hilite_o, ec, src, pr, sh, hl);
    end
  endtask

  task automatic px(logic [6:0] s, logic [6:0] a, logic [6:0] b, logic [6:0] w,
                    logic wa, logic sm);
    spr_px_i = s; pla_px_i = a; plb_px_i = b; win_px_i = w;
    win_act_i = wa; sh_mode_i = sm; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    n_chk++;
    if (valid_o !== 0 || color_o !== 0 || src_o !== 0 || prio_o !== 0 ||
        shadow_o !== 0 || hilite_o !== 0) begin
      n_fail++;
      $display("FAIL R1: got v=%b col=%h src=%0d exp all zero", valid_o, color_o, src_o);
    end
  endtask

  task automatic t_load;
    for (int i = 0; i < 64; i++) begin
      cram_we_i = 1'b1; cram_addr_i = 6'(i); cram_data_i = pat(i); tbl[i] = pat(i);
      @(negedge clk_i);
    end
    cram_we_i = 1'b0;
  endtask

  task automatic t_background;
    bg_idx_i = 6'h15;
    px(7'h00, 7'h00, 7'h00, 7'h00, 0, 0); chk("R3 all clear", 6'h15, 0, 0, 0, 0, 0);
    px(7'h30, 7'h70, 7'h60, 7'h00, 0, 0); chk("R3 pal/prio but clear", 6'h15, 0, 0, 0, 0, 0);
  endtask

  task automatic t_order;
    px(7'h45, 7'h52, 7'h63, 0, 0, 0); chk("R4 hi spr", 6'h05, 1, 1, 0, 0, 0);
    px(7'h07, 7'h52, 7'h63, 0, 0, 0); chk("R4 hi A over lo spr", 6'h12, 2, 1, 0, 0, 0);
    px(7'h07, 7'h12, 7'h63, 0, 0, 0); chk("R4 hi B", 6'h23, 3, 1, 0, 0, 0);
    px(7'h07, 7'h12, 7'h23, 0, 0, 0); chk("R4 lo spr", 6'h07, 1, 0, 0, 0, 0);
    px(7'h00, 7'h12, 7'h23, 0, 0, 0); chk("R4 lo A", 6'h12, 2, 0, 0, 0, 0);
    px(7'h00, 7'h40, 7'h23, 0, 0, 0); chk("R6 lo B", 6'h23, 3, 0, 0, 0, 0);
  endtask

  task automatic t_window;
    px(7'h07, 7'h52, 7'h23, 7'h49, 1, 0); chk("R5 win hi", 6'h09, 4, 1, 0, 0, 0);
    px(7'h00, 7'h52, 7'h23, 7'h00, 1, 0); chk("R5 win clear", 6'h23, 3, 0, 0, 0, 0);
    px(7'h00, 7'h52, 7'h23, 7'h49, 0, 0); chk("R5 win off", 6'h12, 2, 1, 0, 0, 0);
  endtask

  task automatic t_cram;
    cram_we_i = 1'b1; cram_addr_i = 6'h09; cram_data_i = 12'h3C7;
    px(7'h09, 0, 0, 0, 0, 0); cram_we_i = 1'b0;
    chk("R7 old on same cycle", 6'h09, 1, 0, 0, 0, 0);
    tbl[9] = 12'h3C7;
    px(7'h09, 0, 0, 0, 0, 0); chk("R7 new after write", 6'h09, 1, 0, 0, 0, 0);
  endtask

  task automatic t_valid;
    logic [11:0] c;
    c = color_o;
    spr_px_i = 7'h4A; valid_i = 1'b0;
    @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b0 || color_o !== c) begin
      n_fail++;
      $display("FAIL R2: got v=%b col=%h exp v=0 col=%h", valid_o, color_o, c);
    end
  endtask

  task automatic t_shadow;
    bg_idx_i = 6'h2B;
    px(7'h3F, 7'h12, 7'h63, 0, 0, 1); chk("R8 shadow op hi B", 6'h23, 3, 1, 1, 0, 1);
    px(7'h7F, 7'h52, 7'h63, 0, 0, 1); chk("R8 shadow op hi A", 6'h12, 2, 1, 1, 0, 1);
    px(7'h3F, 7'h12, 7'h23, 0, 0, 1); chk("R8 shadow op lo A", 6'h12, 2, 0, 1, 0, 1);
    px(7'h3E, 7'h00, 7'h00, 0, 0, 1); chk("R9 hilite op bg", 6'h2B, 0, 0, 0, 1, 1);
    px(7'h3E, 7'h00, 7'h23, 0, 0, 1); chk("R9 hilite op lo B", 6'h23, 3, 0, 0, 1, 1);
    px(7'h07, 7'h12, 7'h23, 0, 0, 1); chk("R10 no prio shadowed", 6'h07, 1, 0, 1, 0, 1);
    px(7'h07, 7'h40, 7'h23, 0, 0, 1); chk("R10 clear prio plane", 6'h07, 1, 0, 0, 0, 1);
    px(7'h00, 7'h00, 7'h00, 0, 0, 1); chk("R10 bg shadowed", 6'h2B, 0, 0, 1, 0, 1);
    px(7'h45, 7'h12, 7'h23, 0, 0, 1); chk("R11 hi spr masked", 6'h05, 1, 1, 0, 0, 1);
  endtask

  task automatic t_sh_off;
    px(7'h3F, 7'h52, 7'h23, 0, 0, 0); chk("R12 0x3F plain", 6'h12, 2, 1, 0, 0, 0);
    px(7'h3F, 7'h12, 7'h23, 0, 0, 0); chk("R12 0x3F drawn", 6'h3F, 1, 0, 0, 0, 0);
    px(7'h3E, 7'h00, 7'h00, 0, 0, 0); chk("R12 0x3E drawn", 6'h3E, 1, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_load;
    t_background;
    t_order;
    t_window;
    t_cram;
    t_valid;
    t_shadow;
    t_sh_off;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule